// File: doc/BRIEF.md
# Five-Port Oldest-First Dispatch Scheduler

This block holds a small window of decoded micro-operations that wait for their operands. Each entry carries two source tags with ready flags, a destination tag, the number of the execution port it must use and a sequence number. Every clock the scheduler looks at each port on its own. It picks at most one entry that has both operands and whose port is not busy, and when several compete it gives the port to the oldest. A chosen entry leaves the window at the next edge.

Finished execution units broadcast result tags, up to one per port per cycle. Any waiting source whose tag matches one of them becomes ready at the next edge. This includes a source that is being written into the window in the same cycle. A branch that turns out to be mispredicted is reported by its sequence number, and every younger entry is thrown away.

Sequence numbers come from a wrapping counter inside the block, and each accepted entry is told its number. Age is always measured as the distance back from the next number to be handed out. The block stops accepting entries before the oldest live entry could fall out of that range, so the ordering stays correct across wraparound.

Top module: `disp_sched`

## Requirements
- R1: An entry may be dispatched only when both of its source ready flags are set and `port_busy` for its port is low in that cycle; `issue_valid[p]` is combinational from the stored state and the current inputs.
- R2: Each port issues at most one entry per cycle, and an entry is only issued on the port whose number (0 to PORTS-1) it stored at allocation; `issue_dst` carries that entry's destination tag.
- R3: Age of an entry is (next sequence number minus the entry's sequence number) modulo 2^SEQ_W. Among eligible entries for a port, the one with the largest age wins, and `issue_seq` shows its sequence number.
- R4: An entry issued in a cycle is removed from the window at the following clock edge and is never issued again.
- R5: When `bcast_valid[p]` is high, every stored source whose tag equals `bcast_tag[p]` becomes ready at the clock edge, and so does a matching source of an entry accepted in that cycle. The entry may issue from the next cycle on.
- R6: While `flush_valid` is high, every entry whose age is smaller than the age of `flush_seq` is not issued and is removed at the clock edge. The entry with that number and all older ones stay.
- R7: `alloc_ready` is high only when the window has a free slot, no live entry has age 2^SEQ_W-1, and `flush_valid` is low. An entry is accepted when `alloc_valid` and `alloc_ready` are both high.
- R8: `alloc_seq` is the sequence number given to the next accepted entry. It steps by one per accepted entry, modulo 2^SEQ_W.
- R9: After reset the window is empty, no port issues, `alloc_ready` is high and `alloc_seq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A new entry is offered |
| alloc_ready | output | 1 | The offered entry can be taken this cycle |
| alloc_src0_tag | input | TAG_W | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1_tag | input | TAG_W | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_dst_tag | input | TAG_W | Destination tag |
| alloc_port | input | PORT_W | Required execution port number |
| alloc_seq | output | SEQ_W | Sequence number given to the offered entry |
| port_busy | input | PORTS | Per-port busy mask |
| bcast_valid | input | PORTS | Result broadcast valid, one per lane |
| bcast_tag | input | PORTS*TAG_W | Result tags, lane p at bits p*TAG_W upward |
| flush_valid | input | 1 | Mispredicted branch report |
| flush_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| issue_valid | output | PORTS | An entry is dispatched on port p |
| issue_seq | output | PORTS*SEQ_W | Sequence number of the dispatched entry per port |
| issue_dst | output | PORTS*TAG_W | Destination tag of the dispatched entry per port |

## Verification
Assertions check some rules on every cycle. A busy port stays silent, an issued entry has both flags set and sits on the matching port, and no entry is granted to two ports. Issued and flushed entries are gone one cycle later, a broadcast tag sets the flag it matches, and sequence numbers step by one. Whether the oldest entry really won a port, and whether the flush boundary and the age-window stall fall in the right place, need a reference model. The bench keeps that model and compares against it under random traffic, a window filled behind busy ports, and a long-held entry that forces the age stall.

// File: rtl/disp_pkg.sv
package disp_pkg;

   localparam int DIST_W = 16;

   // Order in which the free-slot finder scans the window.
   typedef enum logic [0:0] {
      SCAN_LOW_FIRST  = 1'b0,
      SCAN_HIGH_FIRST = 1'b1
   } slot_scan_e;

   // Modular distance from val back to ref_v on a w-bit wrapping counter.
   function automatic logic [DIST_W-1:0] wrap_dist(
      input logic [DIST_W-1:0] ref_v,
      input logic [DIST_W-1:0] val,
      input int unsigned       w
   );
      logic [DIST_W-1:0] msk;
      msk = (DIST_W'(1) << w) - DIST_W'(1);
      return (ref_v - val) & msk;
   endfunction

endpackage

// File: rtl/disp_free_find.sv
module disp_free_find
   import disp_pkg::*;
#(
   parameter int         N    = 8,
   parameter slot_scan_e SCAN = SCAN_LOW_FIRST
) (
   input  logic [N-1:0] used,
   output logic [N-1:0] free_oh,
   output logic         full
);

   assign full = &used;

   generate
      if (SCAN == SCAN_LOW_FIRST) begin : g_low
         logic hit;
         always_comb begin
            free_oh = '0;
            hit     = 1'b0;
            for (int i = 0; i < N; i++) begin
               if (!used[i] && !hit) begin
                  free_oh[i] = 1'b1;
                  hit        = 1'b1;
               end
            end
         end
      end else begin : g_high
         logic hit;
         always_comb begin
            free_oh = '0;
            hit     = 1'b0;
            for (int i = N - 1; i >= 0; i--) begin
               if (!used[i] && !hit) begin
                  free_oh[i] = 1'b1;
                  hit        = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/disp_wakeup.sv
module disp_wakeup #(
   parameter int TAG_W = 6,
   parameter int LANES = 5
) (
   input  logic [TAG_W-1:0]       tag,
   input  logic [LANES-1:0]       bc_valid,
   input  logic [LANES*TAG_W-1:0] bc_tag,
   output logic                   hit
);

   always_comb begin
      hit = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         if (bc_valid[l] && (bc_tag[l*TAG_W +: TAG_W] == tag)) hit = 1'b1;
      end
   end

endmodule

// File: rtl/disp_oldest_pick.sv
module disp_oldest_pick #(
   parameter int N     = 8,
   parameter int AGE_W = 5,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]       req,
   input  logic [N*AGE_W-1:0] age,
   output logic [N-1:0]       grant,
   output logic               gvalid,
   output logic [IW-1:0]      gidx
);

   logic [AGE_W-1:0] best;

   always_comb begin
      gvalid = 1'b0;
      gidx   = '0;
      best   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!gvalid || (age[i*AGE_W +: AGE_W] > best))) begin
            gvalid = 1'b1;
            gidx   = IW'(i);
            best   = age[i*AGE_W +: AGE_W];
         end
      end
      grant = gvalid ? (N'(1) << gidx) : '0;
   end

endmodule

// File: rtl/disp_sched.sv
module disp_sched
   import disp_pkg::*;
#(
   parameter int         ENTRIES = 8,
   parameter int         PORTS   = 5,
   parameter int         TAG_W   = 6,
   parameter int         SEQ_W   = 5,
   parameter slot_scan_e SCAN    = SCAN_LOW_FIRST,
   localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1,
   localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc_valid,
   output logic                   alloc_ready,
   input  logic [TAG_W-1:0]       alloc_src0_tag,
   input  logic                   alloc_src0_rdy,
   input  logic [TAG_W-1:0]       alloc_src1_tag,
   input  logic                   alloc_src1_rdy,
   input  logic [TAG_W-1:0]       alloc_dst_tag,
   input  logic [PORT_W-1:0]      alloc_port,
   output logic [SEQ_W-1:0]       alloc_seq,
   input  logic [PORTS-1:0]       port_busy,
   input  logic [PORTS-1:0]       bcast_valid,
   input  logic [PORTS*TAG_W-1:0] bcast_tag,
   input  logic                   flush_valid,
   input  logic [SEQ_W-1:0]       flush_seq,
   output logic [PORTS-1:0]       issue_valid,
   output logic [PORTS*SEQ_W-1:0] issue_seq,
   output logic [PORTS*TAG_W-1:0] issue_dst
);

   localparam logic [SEQ_W-1:0] AGE_LIMIT = {SEQ_W{1'b1}};

   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2 || PORTS < 1 || TAG_W < 1) begin : g_bad_size
         initial $error("disp_sched: ENTRIES, PORTS or TAG_W out of range");
      end
      if (SEQ_W <= IW || SEQ_W > DIST_W) begin : g_bad_seq
         initial $error("disp_sched: SEQ_W must exceed log2(ENTRIES) and fit DIST_W");
      end
   endgenerate

   // window state
   logic [ENTRIES-1:0] e_valid;
   logic [ENTRIES-1:0] e_r0;
   logic [ENTRIES-1:0] e_r1;
   logic [SEQ_W-1:0]   e_seq  [ENTRIES];
   logic [TAG_W-1:0]   e_t0   [ENTRIES];
   logic [TAG_W-1:0]   e_t1   [ENTRIES];
   logic [TAG_W-1:0]   e_dst  [ENTRIES];
   logic [PORT_W-1:0]  e_port [ENTRIES];
   logic [SEQ_W-1:0]   next_seq;

   // derived per-entry signals
   logic [SEQ_W-1:0]         e_age [ENTRIES];
   logic [ENTRIES*SEQ_W-1:0] age_flat;
   logic [ENTRIES-1:0]       kill;
   logic [ENTRIES-1:0]       elig;
   logic [ENTRIES-1:0]       w0;
   logic [ENTRIES-1:0]       w1;
   logic [ENTRIES-1:0]       grant_any;
   logic [PORTS-1:0]         grant_col [ENTRIES];
   logic [PORTS-1:0][ENTRIES-1:0] grant_mat;
   logic [SEQ_W-1:0]         flush_age;
   logic [SEQ_W-1:0]         max_age;
   logic [ENTRIES-1:0]       free_oh;
   logic                     win_full;
   logic                     a0_hit;
   logic                     a1_hit;
   logic                     alloc_fire;

   assign flush_age = SEQ_W'(wrap_dist(DIST_W'(next_seq), DIST_W'(flush_seq), SEQ_W));

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         assign e_age[e] = SEQ_W'(wrap_dist(DIST_W'(next_seq), DIST_W'(e_seq[e]), SEQ_W));
         assign age_flat[e*SEQ_W +: SEQ_W] = e_age[e];
         assign kill[e] = flush_valid & e_valid[e] & (e_age[e] < flush_age);
         assign elig[e] = e_valid[e] & e_r0[e] & e_r1[e] & ~kill[e];

         disp_wakeup #(.TAG_W(TAG_W), .LANES(PORTS)) u_wk0 (
            .tag(e_t0[e]), .bc_valid(bcast_valid), .bc_tag(bcast_tag), .hit(w0[e])
         );
         disp_wakeup #(.TAG_W(TAG_W), .LANES(PORTS)) u_wk1 (
            .tag(e_t1[e]), .bc_valid(bcast_valid), .bc_tag(bcast_tag), .hit(w1[e])
         );
      end
   endgenerate

   disp_wakeup #(.TAG_W(TAG_W), .LANES(PORTS)) u_wk_a0 (
      .tag(alloc_src0_tag), .bc_valid(bcast_valid), .bc_tag(bcast_tag), .hit(a0_hit)
   );
   disp_wakeup #(.TAG_W(TAG_W), .LANES(PORTS)) u_wk_a1 (
      .tag(alloc_src1_tag), .bc_valid(bcast_valid), .bc_tag(bcast_tag), .hit(a1_hit)
   );

   // per-port oldest-first selection
   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         logic [ENTRIES-1:0] req;
         logic [ENTRIES-1:0] grant;
         logic               gv;
         logic [IW-1:0]      gidx;

         always_comb begin
            for (int e = 0; e < ENTRIES; e++) begin
               req[e] = elig[e] && (e_port[e] == PORT_W'(p)) && !port_busy[p];
            end
         end

         disp_oldest_pick #(.N(ENTRIES), .AGE_W(SEQ_W)) u_pick (
            .req(req), .age(age_flat), .grant(grant), .gvalid(gv), .gidx(gidx)
         );

         assign grant_mat[p]                    = grant;
         assign issue_valid[p]                  = gv;
         assign issue_seq[p*SEQ_W +: SEQ_W]     = e_seq[gidx];
         assign issue_dst[p*TAG_W +: TAG_W]     = e_dst[gidx];

         AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy[p] |-> !issue_valid[p]);  // R1
         AST_ISSUE_HAS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[p] |-> (e_valid[gidx] && e_r0[gidx] && e_r1[gidx]));  // R1
         AST_ISSUE_RIGHT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[p] |-> (e_port[gidx] == PORT_W'(p)));  // R2
      end
   endgenerate

   always_comb begin
      for (int e = 0; e < ENTRIES; e++) begin
         for (int p = 0; p < PORTS; p++) grant_col[e][p] = grant_mat[p][e];
         grant_any[e] = |grant_col[e];
      end
   end

   // age window bound
   always_comb begin
      max_age = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (e_valid[e] && (e_age[e] > max_age)) max_age = e_age[e];
      end
   end

   disp_free_find #(.N(ENTRIES), .SCAN(SCAN)) u_free (
      .used(e_valid), .free_oh(free_oh), .full(win_full)
   );

   assign alloc_ready = !win_full && (max_age != AGE_LIMIT) && !flush_valid;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_seq   = next_seq;

   // control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid  <= '0;
         next_seq <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (alloc_fire && free_oh[e])       e_valid[e] <= 1'b1;
            else if (grant_any[e] || kill[e])   e_valid[e] <= 1'b0;
         end
         if (alloc_fire) next_seq <= next_seq + 1'b1;
      end
   end

   // payload and ready flags
   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (alloc_fire && free_oh[e]) begin
            e_seq[e]  <= next_seq;
            e_t0[e]   <= alloc_src0_tag;
            e_t1[e]   <= alloc_src1_tag;
            e_dst[e]  <= alloc_dst_tag;
            e_port[e] <= alloc_port;
            e_r0[e]   <= alloc_src0_rdy | a0_hit;
            e_r1[e]   <= alloc_src1_rdy | a1_hit;
         end else begin
            if (w0[e]) e_r0[e] <= 1'b1;
            if (w1[e]) e_r1[e] <= 1'b1;
         end
      end
   end

   // per-entry checks
   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
         AST_ONE_PORT_PER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_col[e]));  // R2
         AST_ISSUED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
            grant_any[e] |=> !e_valid[e]);  // R4
         AST_FLUSHED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
            kill[e] |=> !e_valid[e]);  // R6
         AST_WAKE_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
            (e_valid[e] && w0[e] && !grant_any[e] && !kill[e]) |=> e_r0[e]);  // R5
         AST_WAKE_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
            (e_valid[e] && w1[e] && !grant_any[e] && !kill[e]) |=> e_r1[e]);  // R5
      end
   endgenerate

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |=> (alloc_seq == SEQ_W'($past(alloc_seq) + 1'b1)));  // R8
   AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !alloc_ready) |=> $stable(alloc_seq));  // R8
   AST_FREE_SLOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |-> ($onehot(free_oh) && ((free_oh & e_valid) == '0)));  // R7
   AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |-> (int'(alloc_port) < PORTS));  // R2

endmodule

// File: tb/tb_disp_sched.sv
module tb_disp_sched;

   localparam int E          = 8;
   localparam int P          = 5;
   localparam int TW         = 6;
   localparam int SW         = 5;
   localparam int PW         = 3;
   localparam int SMASK      = (1 << SW) - 1;
   localparam int CLK_PERIOD = 10;

   logic           clk;
   logic           rst_n;
   logic           alloc_valid;
   logic           alloc_ready;
   logic [TW-1:0]  alloc_src0_tag;
   logic           alloc_src0_rdy;
   logic [TW-1:0]  alloc_src1_tag;
   logic           alloc_src1_rdy;
   logic [TW-1:0]  alloc_dst_tag;
   logic [PW-1:0]  alloc_port;
   logic [SW-1:0]  alloc_seq;
   logic [P-1:0]   port_busy;
   logic [P-1:0]   bcast_valid;
   logic [P*TW-1:0] bcast_tag;
   logic           flush_valid;
   logic [SW-1:0]  flush_seq;
   logic [P-1:0]   issue_valid;
   logic [P*SW-1:0] issue_seq;
   logic [P*TW-1:0] issue_dst;

   disp_sched #(.ENTRIES(E), .PORTS(P), .TAG_W(TW), .SEQ_W(SW)) dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_src0_tag(alloc_src0_tag), .alloc_src0_rdy(alloc_src0_rdy),
      .alloc_src1_tag(alloc_src1_tag), .alloc_src1_rdy(alloc_src1_rdy),
      .alloc_dst_tag(alloc_dst_tag), .alloc_port(alloc_port), .alloc_seq(alloc_seq),
      .port_busy(port_busy), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
      .flush_valid(flush_valid), .flush_seq(flush_seq),
      .issue_valid(issue_valid), .issue_seq(issue_seq), .issue_dst(issue_dst)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int stall_seen = 0;

   // reference model of the window
   bit mv [E];
   int mseq [E];
   int mt0 [E];
   int mt1 [E];
   bit mr0 [E];
   bit mr1 [E];
   int mdst [E];
   int mport [E];
   int mnext;

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int mage(input int s);
      return (mnext - s) & SMASK;
   endfunction

   function automatic bit bhit(input int tag);
      for (int p = 0; p < P; p++) begin
         if (bcast_valid[p] && (int'(bcast_tag[p*TW +: TW]) == tag)) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic drive(input int mode, input bit first);
      flush_valid = 1'b0;
      flush_seq   = '0;
      case (mode)
         0: begin
            alloc_valid    = ($urandom % 3) != 0;
            alloc_src0_tag = TW'($urandom % 16);
            alloc_src1_tag = TW'($urandom % 16);
            alloc_src0_rdy = $urandom % 2;
            alloc_src1_rdy = $urandom % 2;
            alloc_dst_tag  = TW'($urandom % 64);
            alloc_port     = PW'($urandom % P);
            port_busy      = P'($urandom & $urandom);
            bcast_valid    = P'($urandom);
            for (int p = 0; p < P; p++) bcast_tag[p*TW +: TW] = TW'($urandom % 16);
            if (($urandom % 12) == 0) begin
               int pick;
               pick = $urandom % E;
               for (int k = 0; k < E; k++) begin
                  if (mv[(pick + k) % E]) begin
                     flush_valid = 1'b1;
                     flush_seq   = SW'(mseq[(pick + k) % E]);
                     break;
                  end
               end
            end
         end
         1: begin
            alloc_valid    = 1'b1;
            alloc_src0_tag = TW'($urandom % 16);
            alloc_src1_tag = TW'($urandom % 16);
            alloc_src0_rdy = 1'b1;
            alloc_src1_rdy = 1'b1;
            alloc_dst_tag  = TW'($urandom % 64);
            alloc_port     = PW'($urandom % P);
            port_busy      = '1;
            bcast_valid    = '0;
            bcast_tag      = '0;
         end
         2: begin
            alloc_valid = 1'b0;
            port_busy   = '0;
            bcast_valid = '1;
            for (int p = 0; p < P; p++) bcast_tag[p*TW +: TW] = TW'($urandom % 16);
         end
         default: begin
            alloc_valid    = 1'b1;
            alloc_src0_tag = TW'(20);
            alloc_src1_tag = TW'(21);
            alloc_src0_rdy = 1'b1;
            alloc_src1_rdy = 1'b1;
            alloc_dst_tag  = TW'($urandom % 64);
            alloc_port     = first ? PW'(0) : PW'(1);
            port_busy      = P'(1);
            bcast_valid    = '0;
            bcast_tag      = '0;
         end
      endcase
   endtask

   task automatic check_and_update();
      int cnt;
      int maxa;
      int fage;
      bit kill [E];
      bit issued [E];
      bit exp_ready;
      cnt  = 0;
      maxa = 0;
      for (int e = 0; e < E; e++) begin
         issued[e] = 1'b0;
         if (mv[e]) begin
            cnt++;
            if (mage(mseq[e]) > maxa) maxa = mage(mseq[e]);
         end
      end
      exp_ready = (cnt < E) && (maxa != SMASK) && !flush_valid;
      if ((cnt < E) && !flush_valid && !exp_ready) stall_seen++;
      chk("R7", "alloc_ready", int'(alloc_ready), int'(exp_ready));
      chk("R8", "alloc_seq", int'(alloc_seq), mnext);
      fage = mage(int'(flush_seq));
      for (int e = 0; e < E; e++) kill[e] = flush_valid && mv[e] && (mage(mseq[e]) < fage);
      for (int p = 0; p < P; p++) begin
         int best;
         best = -1;
         for (int e = 0; e < E; e++) begin
            if (mv[e] && mr0[e] && mr1[e] && !kill[e] && (mport[e] == p) && !port_busy[p] &&
                ((best < 0) || (mage(mseq[e]) > mage(mseq[best])))) best = e;
         end
         chk("R1 R5 R6", "issue_valid", int'(issue_valid[p]), int'(best >= 0));
         if (best >= 0) begin
            chk("R3 R4", "issue_seq", int'(issue_seq[p*SW +: SW]), mseq[best]);
            chk("R2", "issue_dst", int'(issue_dst[p*TW +: TW]), mdst[best]);
            issued[best] = 1'b1;
         end
      end
      // state after the clock edge
      for (int e = 0; e < E; e++) begin
         if (issued[e] || kill[e]) mv[e] = 1'b0;
         else if (mv[e]) begin
            if (bhit(mt0[e])) mr0[e] = 1'b1;
            if (bhit(mt1[e])) mr1[e] = 1'b1;
         end
      end
      if (alloc_valid && exp_ready) begin
         for (int e = 0; e < E; e++) begin
            if (!mv[e] && !issued[e] && !kill[e]) begin
               mv[e]    = 1'b1;
               mseq[e]  = mnext;
               mt0[e]   = int'(alloc_src0_tag);
               mt1[e]   = int'(alloc_src1_tag);
               mr0[e]   = alloc_src0_rdy | bhit(int'(alloc_src0_tag));
               mr1[e]   = alloc_src1_rdy | bhit(int'(alloc_src1_tag));
               mdst[e]  = int'(alloc_dst_tag);
               mport[e] = int'(alloc_port);
               break;
            end
         end
         mnext = (mnext + 1) & SMASK;
      end
   endtask

   task automatic step(input int mode, input bit first);
      @(negedge clk);
      drive(mode, first);
      #2;
      check_and_update();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog all requirements actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n          = 1'b0;
      alloc_valid    = 1'b0;
      alloc_src0_tag = '0;
      alloc_src1_tag = '0;
      alloc_src0_rdy = 1'b0;
      alloc_src1_rdy = 1'b0;
      alloc_dst_tag  = '0;
      alloc_port     = '0;
      port_busy      = '0;
      bcast_valid    = '0;
      bcast_tag      = '0;
      flush_valid    = 1'b0;
      flush_seq      = '0;
      mnext          = 0;
      for (int e = 0; e < E; e++) mv[e] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R9 reset state
      chk("R9", "alloc_ready after reset", int'(alloc_ready), 1);
      chk("R9", "alloc_seq after reset", int'(alloc_seq), 0);
      chk("R9", "issue_valid after reset", int'(issue_valid), 0);

      for (int i = 0; i < 2000; i++) step(0, 1'b0);

      // fill the window behind busy ports: R7 full
      for (int i = 0; i < 12; i++) step(1, 1'b0);
      chk("R7", "alloc_ready with full window", int'(alloc_ready), 0);
      for (int i = 0; i < 40; i++) step(2, 1'b0);

      // hold one entry on a busy port until the age window closes: R7 age stall
      stall_seen = 0;
      step(3, 1'b1);
      for (int i = 0; i < 45; i++) step(3, 1'b0);
      chk("R7", "age window stall observed", int'(stall_seen > 0), 1);
      for (int i = 0; i < 40; i++) step(2, 1'b0);

      for (int i = 0; i < 1500; i++) step(0, 1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule